// File: doc/BRIEF.md
# Two-Level Peripheral Interrupt Controller

This block merges sticky event flags from a set of peripherals into a single processor interrupt request. Each peripheral reports an event with a one-cycle set pulse, and that pulse latches a bit in a flag register. Every flag register has a matching enable register of the same width. A source takes part in a request only when its flag and its own enable bit are both 1. The block has two flag/enable register pairs by default, and the masked results of all of them are ORed together.

A core control register holds two masks. The group peripheral enable gates the combined masked flags. The result is the wake request, which ends processor sleep. The global enable gates the wake request a second time to form the interrupt request, which sends the processor to its handler. So a source that is enabled locally and by the group can wake a sleeping core while global interrupts are off, and no handler jump follows.

On handler entry the global enable clears by itself, and a return strobe sets it again. Software clears a flag by writing 0 to its bit. A hardware set pulse in the same cycle wins over that clear. By convention the converter-complete source uses bit 6 of the first flag/enable pair.

Top module: `periph_irq_ctrl`

## Requirements
- R1: After synchronous reset every register reads 0, and `irq_req` and `wake_req` are 0.
- R2: A 1 on a bit of `src_set` sets the matching flag bit on the next clock edge. Bit k*8+i maps to bit i of flag register k. The flag stays 1 until software clears it.
- R3: A write to a flag register clears each bit written 0. Bits written 1 keep their value.
- R4: When a set pulse and a software clear hit the same flag bit in the same cycle, the flag ends up 1.
- R5: `wake_req` is 1 exactly when the group enable (bit 6 of the core register, address 0) is 1 and some flag bit has its matching enable bit set. The global enable plays no part in this.
- R6: `irq_req` is 1 exactly when `wake_req` is 1 and the global enable (bit 7 of the core register) is 1.
- R7: `handler_enter` clears the global enable and `handler_return` sets it. When both strobes arrive, `handler_enter` wins. Either strobe wins over a software write to bit 7 in the same cycle, but a software write to bit 6 still takes effect.
- R8: The masked flags of the second pair (flags at address 3, enables at address 4) are ORed with those of the first pair (flags at address 1, enables at address 2).
- R9: A flag that is already set raises a request in the cycle after its enable bit is written to 1.
- R10: Core register bits other than 7 and 6 read 0. Reads from an unmapped address return 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: 0 core, 1+2k flags of pair k, 2+2k enables of pair k |
| wr_data | input | WIDTH | Write data |
| rd_addr | input | ADDR_W | Read address, same map as the write address |
| rd_data | output | WIDTH | Read data for `rd_addr`, combinational |
| src_set | input | NUM_BANKS*WIDTH | Peripheral set pulses, one bit per flag |
| handler_enter | input | 1 | Strobe: the processor has entered its handler |
| handler_return | input | 1 | Strobe: return from interrupt |
| irq_req | output | 1 | Request to jump to the handler |
| wake_req | output | 1 | Request to leave sleep |

## Verification
The assertions assume that the inputs change only between clock edges and that reset holds for at least one edge. They also assume that the handler strobes are one-cycle pulses coming from the core's own sequencing. The stimulus changes all inputs on the falling edge and raises each strobe for exactly one cycle. It also issues overlapping strobes and writes on purpose, so that the precedence rules in the checks are exercised.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int CORE_ADDR  = 0;
    localparam int GLOBAL_BIT = 7;
    localparam int GROUP_BIT  = 6;

    typedef struct packed {
        logic global_en;
        logic group_en;
    } core_ctrl_t;

    typedef enum logic [1:0] {
        GSRC_HOLD   = 2'd0,
        GSRC_WRITE  = 2'd1,
        GSRC_RETURN = 2'd2,
        GSRC_ENTER  = 2'd3
    } gsrc_e;

    function automatic int flag_addr(input int bank);
        return 1 + 2 * bank;
    endfunction

    function automatic int en_addr(input int bank);
        return 2 + 2 * bank;
    endfunction

    function automatic gsrc_e pick_gsrc(input logic enter, input logic ret, input logic we);
        if (enter)     return GSRC_ENTER;
        else if (ret)  return GSRC_RETURN;
        else if (we)   return GSRC_WRITE;
        else           return GSRC_HOLD;
    endfunction

endpackage

// File: rtl/intc_flag_bank.sv
module intc_flag_bank #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_pulse,
    input  logic             flag_we,
    input  logic             en_we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] flags,
    output logic [WIDTH-1:0] enables,
    output logic             pending
);

    logic [WIDTH-1:0] flags_nxt;

    always_comb begin
        flags_nxt = flags;
        if (flag_we) flags_nxt = flags_nxt & wdata;
        flags_nxt = flags_nxt | set_pulse;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            enables <= '0;
        end else begin
            flags <= flags_nxt;
            if (en_we) enables <= wdata;
        end
    end

    assign pending = |(flags & enables);

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|set_pulse) |=> ((flags & $past(set_pulse)) == $past(set_pulse))); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!flag_we) |=> ((flags & $past(flags)) == $past(flags))); // R2

    AST_EN_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!en_we) |=> $stable(enables)); // R10

endmodule

// File: rtl/intc_core_ctrl.sv
module intc_core_ctrl
    import intc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    input  logic             handler_enter,
    input  logic             handler_return,
    output core_ctrl_t       ctrl
);

    gsrc_e gsrc;
    logic  global_nxt;

    always_comb begin
        gsrc = pick_gsrc(handler_enter, handler_return, we);
        unique case (gsrc)
            GSRC_ENTER:  global_nxt = 1'b0;
            GSRC_RETURN: global_nxt = 1'b1;
            GSRC_WRITE:  global_nxt = wdata[GLOBAL_BIT];
            default:     global_nxt = ctrl.global_en;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else begin
            ctrl.global_en <= global_nxt;
            if (we) ctrl.group_en <= wdata[GROUP_BIT];
        end
    end

    AST_ENTER_MASKS: assert property (@(posedge clk) disable iff (rst)
        handler_enter |=> !ctrl.global_en); // R7

    AST_RETURN_UNMASKS: assert property (@(posedge clk) disable iff (rst)
        (handler_return && !handler_enter) |=> ctrl.global_en); // R7

endmodule

// File: rtl/intc_req_combine.sv
module intc_req_combine
    import intc_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BANKS-1:0] bank_pending,
    input  core_ctrl_t           ctrl,
    output logic                 wake_req,
    output logic                 irq_req
);

    logic any_pending;

    assign any_pending = |bank_pending;
    assign wake_req    = any_pending & ctrl.group_en;
    assign irq_req     = wake_req & ctrl.global_en;

    AST_WAKE_NEEDS_GROUP: assert property (@(posedge clk) disable iff (rst)
        !ctrl.group_en |-> !wake_req); // R5

    AST_IRQ_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (rst)
        !ctrl.global_en |-> !irq_req); // R6

    AST_IRQ_IMPLIES_WAKE: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> wake_req); // R6

endmodule

// File: rtl/periph_irq_ctrl.sv
module periph_irq_ctrl
    import intc_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [WIDTH-1:0]           wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [WIDTH-1:0]           rd_data,
    input  logic [NUM_BANKS*WIDTH-1:0] src_set,
    input  logic                       handler_enter,
    input  logic                       handler_return,
    output logic                       irq_req,
    output logic                       wake_req
);

    localparam int LAST_ADDR = en_addr(NUM_BANKS - 1);

    core_ctrl_t           ctrl;
    logic [NUM_BANKS-1:0] bank_pending;
    logic [WIDTH-1:0]     bank_flags [NUM_BANKS];
    logic [WIDTH-1:0]     bank_ens   [NUM_BANKS];
    logic                 core_we;

    assign core_we = wr_en && (wr_addr == ADDR_W'(CORE_ADDR));

    intc_core_ctrl #(.WIDTH(WIDTH)) core_i (
        .clk            (clk),
        .rst            (rst),
        .we             (core_we),
        .wdata          (wr_data),
        .handler_enter  (handler_enter),
        .handler_return (handler_return),
        .ctrl           (ctrl)
    );

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        logic fwe, ewe;
        assign fwe = wr_en && (wr_addr == ADDR_W'(flag_addr(k)));
        assign ewe = wr_en && (wr_addr == ADDR_W'(en_addr(k)));

        intc_flag_bank #(.WIDTH(WIDTH)) bank_i (
            .clk       (clk),
            .rst       (rst),
            .set_pulse (src_set[k*WIDTH +: WIDTH]),
            .flag_we   (fwe),
            .en_we     (ewe),
            .wdata     (wr_data),
            .flags     (bank_flags[k]),
            .enables   (bank_ens[k]),
            .pending   (bank_pending[k])
        );
    end

    intc_req_combine #(.NUM_BANKS(NUM_BANKS)) comb_i (
        .clk          (clk),
        .rst          (rst),
        .bank_pending (bank_pending),
        .ctrl         (ctrl),
        .wake_req     (wake_req),
        .irq_req      (irq_req)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(CORE_ADDR)) begin
            rd_data[GLOBAL_BIT] = ctrl.global_en;
            rd_data[GROUP_BIT]  = ctrl.group_en;
        end
        for (int k = 0; k < NUM_BANKS; k++) begin
            if (rd_addr == ADDR_W'(flag_addr(k))) rd_data = bank_flags[k];
            if (rd_addr == ADDR_W'(en_addr(k)))   rd_data = bank_ens[k];
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!irq_req && !wake_req)); // R1

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_addr) > LAST_ADDR) |-> (rd_data == '0)); // R10

endmodule

// File: tb/periph_irq_ctrl_tb.sv
module periph_irq_ctrl_tb_top;

    localparam int WIDTH = 8;
    localparam int NB    = 2;
    localparam int AW    = 3;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [WIDTH-1:0]  wr_data;
    logic [AW-1:0]     rd_addr;
    logic [WIDTH-1:0]  rd_data;
    logic [NB*WIDTH-1:0] src_set;
    logic              handler_enter, handler_return;
    logic              irq_req, wake_req;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    periph_irq_ctrl #(.WIDTH(WIDTH), .NUM_BANKS(NB), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .src_set(src_set),
        .handler_enter(handler_enter), .handler_return(handler_return),
        .irq_req(irq_req), .wake_req(wake_req)
    );

    typedef struct packed {
        logic        we;
        logic [2:0]  wa;
        logic [7:0]  wd;
        logic [15:0] set;
        logic        ent;
        logic        ret;
        logic [2:0]  ra;
        logic [7:0]  erd;
        logic        eirq;
        logic        ewake;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd0, 8'h00, 16'h0040, 1'b0, 1'b0, 3'd1, 8'h40, 1'b0, 1'b0}, // R2 set pulse
        '{1'b1, 3'd2, 8'h40, 16'h0000, 1'b0, 1'b0, 3'd1, 8'h40, 1'b0, 1'b0}, // R5 no group
        '{1'b1, 3'd0, 8'h40, 16'h0000, 1'b0, 1'b0, 3'd0, 8'h40, 1'b0, 1'b1}, // R5 wake w/o global
        '{1'b1, 3'd0, 8'hC0, 16'h0000, 1'b0, 1'b0, 3'd0, 8'hC0, 1'b1, 1'b1}, // R6
        '{1'b0, 3'd0, 8'h00, 16'h0000, 1'b1, 1'b0, 3'd0, 8'h40, 1'b0, 1'b1}, // R7 enter
        '{1'b1, 3'd1, 8'hBF, 16'h0000, 1'b0, 1'b0, 3'd1, 8'h00, 1'b0, 1'b0}, // R3 clear
        '{1'b0, 3'd0, 8'h00, 16'h0000, 1'b0, 1'b1, 3'd0, 8'hC0, 1'b0, 1'b0}, // R7 return
        '{1'b0, 3'd0, 8'h00, 16'h0100, 1'b0, 1'b0, 3'd3, 8'h01, 1'b0, 1'b0}, // R8 flag B
        '{1'b1, 3'd4, 8'h01, 16'h0000, 1'b0, 1'b0, 3'd4, 8'h01, 1'b1, 1'b1}, // R8 R9
        '{1'b1, 3'd3, 8'h00, 16'h0100, 1'b0, 1'b0, 3'd3, 8'h01, 1'b1, 1'b1}, // R4
        '{1'b1, 3'd3, 8'hFE, 16'h0000, 1'b0, 1'b0, 3'd3, 8'h00, 1'b0, 1'b0}, // R3
        '{1'b1, 3'd0, 8'hFF, 16'h0000, 1'b0, 1'b0, 3'd0, 8'hC0, 1'b0, 1'b0}, // R10 core bits
        '{1'b1, 3'd7, 8'hFF, 16'h0000, 1'b0, 1'b0, 3'd7, 8'h00, 1'b0, 1'b0}, // R10 unmapped
        '{1'b1, 3'd0, 8'hC0, 16'h0000, 1'b1, 1'b1, 3'd0, 8'h40, 1'b0, 1'b0}, // R7 priority
        '{1'b0, 3'd0, 8'h00, 16'h0003, 1'b0, 1'b0, 3'd1, 8'h03, 1'b0, 1'b0}, // R2
        '{1'b1, 3'd1, 8'h01, 16'h0000, 1'b0, 1'b0, 3'd1, 8'h01, 1'b0, 1'b0}, // R3 keep ones
        '{1'b1, 3'd0, 8'h80, 16'h0000, 1'b0, 1'b0, 3'd0, 8'h80, 1'b0, 1'b0}, // R6 global only
        '{1'b0, 3'd0, 8'h00, 16'h0040, 1'b0, 1'b0, 3'd1, 8'h41, 1'b0, 1'b0}, // R5 group off
        '{1'b1, 3'd0, 8'hC0, 16'h0000, 1'b0, 1'b0, 3'd0, 8'hC0, 1'b1, 1'b1}  // R9 R6
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; src_set = '0;
        handler_enter = 1'b0; handler_return = 1'b0;
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        idle();
        rd_addr = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < 5; a++) begin
            rd_addr = AW'(a);
            #1 chk("R1 reset reg", 32'(rd_data), 32'h0);
        end
        chk("R1 reset irq", 32'(irq_req), 32'h0);
        chk("R1 reset wake", 32'(wake_req), 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VECS[i].we; wr_addr = VECS[i].wa; wr_data = VECS[i].wd;
            src_set = VECS[i].set; handler_enter = VECS[i].ent;
            handler_return = VECS[i].ret; rd_addr = VECS[i].ra;
            @(posedge clk);
            #1;
            idle();
            chk($sformatf("vec%0d rd", i), 32'(rd_data), 32'(VECS[i].erd));
            chk($sformatf("vec%0d irq", i), 32'(irq_req), 32'(VECS[i].eirq));
            chk($sformatf("vec%0d wake", i), 32'(wake_req), 32'(VECS[i].ewake));
        end

        // R7: enter clears global even during a write of 1; group write applies
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h80; handler_enter = 1'b1;
        @(posedge clk); #1; idle(); rd_addr = 3'd0; #1;
        chk("R7 enter over write", 32'(rd_data), 32'h00);

        // R1: mid-run reset clears everything
        @(negedge clk);
        src_set = 16'hFFFF; rst = 1'b1;
        @(posedge clk); #1; idle();
        @(negedge clk); rst = 1'b0;
        for (int a = 0; a < 5; a++) begin
            rd_addr = AW'(a);
            #1 chk("R1 mid reset reg", 32'(rd_data), 32'h0);
        end
        chk("R1 mid reset wake", 32'(wake_req), 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule